// File: doc/BRIEF.md
# Serial Converter Command and Result Front End

This block is the device-side digital front end of a multi-channel serial analog-to-digital converter. A host frames each transaction by pulling an active-low select low and toggling a serial clock. During the frame the block does four things:

- It receives an 8-bit command byte, most significant bit first. The upper nibble names the channel to convert next; the lower nibble carries configuration.
- It returns the 12-bit result of the previous conversion, most significant bit first.
- It opens a sampling window for the analog front end.
- On the last falling edge of the frame, it hands a start request and the channel to the conversion engine.

All host signals are brought into a fast system clock through two-flop synchronizers, and edges are detected there. The system clock must run at least four times faster than the serial clock.

A status output tells the host when a result is ready. It works in one of two styles, chosen by a configuration bit of the command byte. In the busy style, the output is low while the conversion runs. In the interrupt style, it falls when the data is ready and is cleared by the next serial clock rising edge.

The conversion engine itself sits outside the block. It receives a start pulse with a channel number and later returns a done pulse with 12 data bits.

Top module: `sadc_frontend`

## Requirements
- R1: After reset, sdo_oe, sample_win and conv_start are 0 and status_n is 1. The stored result is zero, so the first frame after reset shifts out twelve 0 bits.
- R2: sdo_oe is 1 only while a frame is open (cs_n low), and sample_win is never 1 while sdo_oe is 0.
- R3: Command bits are taken MSB first on the first eight sclk rising edges. The first four bits received (D7..D4) form the channel number, which appears on conv_chan together with conv_start.
- R4: sample_win rises after the 4th sclk falling edge of a frame and falls on the 12th falling edge.
- R5: When cs_n falls, sdo presents bit 11 of the stored result. Each later sclk falling edge advances sdo by one bit, down to bit 0.
- R6: conv_start is a single-cycle pulse issued after the 12th sclk falling edge, and only while the frame is open.
- R7: When the last command bit (D0) is 0 (busy style), status_n goes low with conv_start and returns to 1 once conv_done arrives.
- R8: When D0 is 1 (interrupt style), status_n stays 1 during the conversion, falls the cycle after conv_done, and returns to 1 on the next sclk rising edge.
- R9: sclk edges after the 12th in a frame are ignored: no second start, sdo holds bit 0, and sample_win stays 0.
- R10: A frame closed before 12 falling edges starts no conversion and leaves the stored result unchanged. The next frame counts its edges from zero.
- R11: A result that arrives while a frame is open does not alter the bits shifted out in that frame. It is shifted out in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select from host |
| sclk | input | 1 | Host serial clock |
| sdi | input | 1 | Serial command data, MSB first |
| sdo | output | 1 | Serial result data, MSB first |
| sdo_oe | output | 1 | Output enable for sdo (tri-state control at the pad) |
| sample_win | output | 1 | Sampling window for the analog input |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 4 | Channel number issued with conv_start |
| conv_done | input | 1 | One-cycle pulse from the converter when data is ready |
| conv_data | input | 12 | Conversion result, valid with conv_done |
| status_n | output | 1 | Active-low ready or busy status |

## Verification
The bench drives whole and partial frames and compares every shifted bit against the previous conversion result.

- **Off-by-one edge counting.** A design that miscounts edges would shift a bit early or late, or move the sampling window by one edge.
- **Short frames.** An aborted frame must not start a conversion; a design that did would bump the start count.
- **Over-long frames.** A design that kept counting would start twice or shift zeros after bit 0.
- **Result landing mid-frame.** A design that reloaded the shift register from a mid-frame result would return a mix of old and new bits.
- **Two status styles.** The bench checks both; an interrupt that is not cleared by the next serial rising edge shows as a stuck low status.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
package sadc_pkg;
  // Status pin style selected by the mode bit of the command byte
  typedef enum logic {
    ST_EOC = 1'b0,  // low while converting
    ST_IRQ = 1'b1   // low once data ready, cleared by sclk rise
  } stat_mode_e;
endpackage

// File: rtl/sadc_edge_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer followed by a rise/fall detector.
module sadc_edge_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;
  logic              lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= {STAGES{IDLE}};
      prev <= IDLE;
    end else begin
      sh   <= {sh[STAGES-2:0], d};
      prev <= sh[STAGES-1];
    end
  end

  assign lvl  = sh[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/sadc_frame_ctl.sv
`timescale 1ns/1ps
// Frame sequencer: counts serial edges within a select frame, opens the
// sample window and decides when to hand off to the converter.
module sadc_frame_ctl #(
  parameter int CMD_W       = 8,
  parameter int FRAME_LEN   = 12,
  parameter int SAMPLE_FALL = 4,
  parameter int RC_W        = $clog2(CMD_W + 1),
  parameter int FC_W        = $clog2(FRAME_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_fall,
  input  logic            cs_rise,
  input  logic            sclk_rise,
  input  logic            sclk_fall,
  output logic            active,
  output logic            win,
  output logic            shift_in,
  output logic [RC_W-1:0] rise_idx,
  output logic            shift_out,
  output logic            load_out,
  output logic            start_ev
);
  localparam logic [RC_W-1:0] RC_MAX  = RC_W'(CMD_W);
  localparam logic [FC_W-1:0] FC_MAX  = FC_W'(FRAME_LEN);
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(FRAME_LEN - 1);
  localparam logic [FC_W-1:0] FC_WIN  = FC_W'(SAMPLE_FALL - 1);

  logic [RC_W-1:0] rise_cnt;
  logic [FC_W-1:0] fall_cnt;
  logic            fall_ok;

  assign shift_in  = active & ~cs_rise & sclk_rise & (rise_cnt != RC_MAX);
  assign fall_ok   = active & ~cs_rise & sclk_fall & (fall_cnt != FC_MAX);
  assign shift_out = fall_ok & (fall_cnt < FC_LAST);
  assign start_ev  = fall_ok & (fall_cnt == FC_LAST);
  assign load_out  = cs_fall;
  assign rise_idx  = rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_cnt <= '0;
      fall_cnt <= '0;
      active   <= 1'b0;
      win      <= 1'b0;
    end else if (cs_fall) begin
      rise_cnt <= '0;
      fall_cnt <= '0;
      active   <= 1'b1;
      win      <= 1'b0;
    end else if (cs_rise) begin
      active   <= 1'b0;
      win      <= 1'b0;
    end else if (active) begin
      if (shift_in) rise_cnt <= rise_cnt + RC_W'(1);
      if (fall_ok) begin
        fall_cnt <= fall_cnt + FC_W'(1);
        if (fall_cnt == FC_WIN)  win <= 1'b1;
        if (fall_cnt == FC_LAST) win <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sadc_cmd_rx.sv
`timescale 1ns/1ps
// Command receiver: MSB-first shifter that latches the channel nibble as
// soon as it is complete and picks the status-style bit out of the config.
module sadc_cmd_rx
  import sadc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CMD_W    = 8,
  parameter int MODE_BIT = 0,
  parameter int RC_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_in,
  input  logic              sdi,
  input  logic [RC_W-1:0]   rise_idx,
  output logic [ADDR_W-1:0] addr,
  output stat_mode_e        mode_sel
);
  localparam logic [RC_W-1:0] ADDR_IDX = RC_W'(ADDR_W - 1);
  localparam logic [RC_W-1:0] MODE_IDX = RC_W'(CMD_W - 1 - MODE_BIT);

  logic [ADDR_W-2:0] sh;
  logic [ADDR_W-1:0] nxt;

  assign nxt = {sh, sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      addr     <= '0;
      mode_sel <= ST_EOC;
    end else if (shift_in) begin
      sh <= nxt[ADDR_W-2:0];
      if (rise_idx == ADDR_IDX) addr     <= nxt;
      if (rise_idx == MODE_IDX) mode_sel <= stat_mode_e'(sdi);
    end
  end
endmodule

// File: rtl/sadc_result_tx.sv
`timescale 1ns/1ps
// Result holding register plus MSB-first output shifter.
module sadc_result_tx #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic             done,
  input  logic [RES_W-1:0] data,
  output logic             sdo
);
  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      sr    <= '0;
    end else begin
      if (done) res_q <= data;
      if (load)       sr <= res_q;
      else if (shift) sr <= {sr[RES_W-2:0], 1'b0};
    end
  end

  assign sdo = sr[RES_W-1];
endmodule

// File: rtl/sadc_status.sv
`timescale 1ns/1ps
// Status pin controller for the busy and interrupt styles.
module sadc_status
  import sadc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  stat_mode_e mode_sel,
  input  logic       done,
  input  logic       sclk_rise,
  output logic       status_n,
  output stat_mode_e mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_n <= 1'b1;
      mode_q   <= ST_EOC;
    end else if (start) begin
      mode_q <= mode_sel;
      if (mode_sel == ST_EOC) status_n <= 1'b0;
    end else if (done) begin
      status_n <= (mode_q == ST_EOC);
    end else if (sclk_rise && mode_q == ST_IRQ) begin
      status_n <= 1'b1;
    end
  end
endmodule

// File: rtl/sadc_frontend.sv
`timescale 1ns/1ps
module sadc_frontend
  import sadc_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int CMD_W       = 8,
  parameter int ADDR_W      = 4,
  parameter int MODE_BIT    = 0,
  parameter int FRAME_LEN   = 12,
  parameter int SAMPLE_FALL = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              sample_win,
  output logic              conv_start,
  output logic [ADDR_W-1:0] conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              status_n
);
  localparam int RC_W = $clog2(CMD_W + 1);
  localparam int FC_W = $clog2(FRAME_LEN + 1);

  logic cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic [SYNC_STAGES-1:0] sdi_sh;
  logic sdi_s;
  logic shift_in, shift_out, load_out, start_ev;
  logic [RC_W-1:0] rise_idx;
  logic [ADDR_W-1:0] addr;
  stat_mode_e mode_sel;
  stat_mode_e stat_mode;

  sadc_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .d(cs_n), .rise(cs_rise), .fall(cs_fall)
  );

  sadc_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_sclk_sync (
    .clk(clk), .rst(rst), .d(sclk), .rise(sclk_rise), .fall(sclk_fall)
  );

  // data lane delayed by the same depth so it lines up with the clock edge
  always_ff @(posedge clk) begin
    if (rst) sdi_sh <= '0;
    else     sdi_sh <= {sdi_sh[SYNC_STAGES-2:0], sdi};
  end
  assign sdi_s = sdi_sh[SYNC_STAGES-1];

  sadc_frame_ctl #(
    .CMD_W(CMD_W), .FRAME_LEN(FRAME_LEN), .SAMPLE_FALL(SAMPLE_FALL),
    .RC_W(RC_W), .FC_W(FC_W)
  ) u_frame (
    .clk(clk), .rst(rst),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .active(sdo_oe), .win(sample_win),
    .shift_in(shift_in), .rise_idx(rise_idx),
    .shift_out(shift_out), .load_out(load_out), .start_ev(start_ev)
  );

  sadc_cmd_rx #(
    .ADDR_W(ADDR_W), .CMD_W(CMD_W), .MODE_BIT(MODE_BIT), .RC_W(RC_W)
  ) u_cmd (
    .clk(clk), .rst(rst), .shift_in(shift_in), .sdi(sdi_s),
    .rise_idx(rise_idx), .addr(addr), .mode_sel(mode_sel)
  );

  sadc_result_tx #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst(rst), .load(load_out), .shift(shift_out),
    .done(conv_done), .data(conv_data), .sdo(sdo)
  );

  sadc_status u_stat (
    .clk(clk), .rst(rst), .start(start_ev), .mode_sel(mode_sel),
    .done(conv_done), .sclk_rise(sclk_rise),
    .status_n(status_n), .mode_q(stat_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_start <= 1'b0;
      conv_chan  <= '0;
    end else begin
      conv_start <= start_ev;
      if (start_ev) conv_chan <= addr;
    end
  end
endmodule

// File: rtl/sadc_frontend_chk.sv
`timescale 1ns/1ps
module sadc_frontend_chk (
  input logic clk,
  input logic rst,
  input logic sdo_oe,
  input logic sample_win,
  input logic conv_start,
  input logic conv_done,
  input logic status_n,
  input logic irq_mode
);
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  assert_start_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> sdo_oe);

  assert_win_close_R4: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (!sample_win && $past(sample_win)));

  assert_win_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sample_win);

  assert_busy_low_R7: assert property (@(posedge clk) disable iff (rst)
    (conv_start && !irq_mode) |-> !status_n);

  assert_irq_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(status_n) && irq_mode) |-> $past(conv_done));
endmodule

bind sadc_frontend sadc_frontend_chk u_chk (
  .clk(clk), .rst(rst), .sdo_oe(sdo_oe), .sample_win(sample_win),
  .conv_start(conv_start), .conv_done(conv_done), .status_n(status_n),
  .irq_mode(stat_mode)
);

// File: tb/sadc_frontend_test.sv
`timescale 1ns/1ps
module sadc_frontend_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, sample_win, conv_start, status_n;
  logic [3:0] conv_chan;
  logic conv_done = 1'b0;
  logic [11:0] conv_data = '0;

  int checks = 0, fails = 0;
  int start_cnt = 0;
  int done_lat = 100;
  logic [3:0] last_chan = '0;
  logic [11:0] exp_prev = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sadc_frontend uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .sample_win(sample_win),
    .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data), .status_n(status_n)
  );

  function automatic logic [11:0] res_of(input logic [3:0] c);
    return {c, ~c, c};
  endfunction

  // converter stub
  int cnt_c = 0;
  bit busy_c = 0;
  logic [3:0] chan_c = '0;
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (rst) busy_c = 0;
    else if (conv_start) begin
      busy_c = 1; cnt_c = done_lat; chan_c = conv_chan;
      start_cnt++; last_chan = conv_chan;
    end else if (busy_c) begin
      if (cnt_c == 0) begin
        conv_done <= 1'b1; conv_data <= res_of(chan_c); busy_c = 0;
      end else cnt_c--;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One host frame of nclk serial clocks; got holds the first 12 sdo bits
  task automatic frame(input logic [7:0] cmd, input int nclk,
                       output logic [11:0] got, output logic last_bit);
    got = '0; last_bit = 1'b0;
    cs_n = 1'b0;
    #80;
    chk("R2", "sdo_oe in frame", sdo_oe, 1);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 8) ? cmd[7-i] : 1'b0;
      #40 sclk = 1'b1;
      #20;
      if (i < 12) got[11-i] = sdo;
      last_bit = sdo;
      chk("R4", $sformatf("sample_win clk %0d", i), sample_win,
          (i >= 4 && i < 12) ? 1 : 0);
      #20 sclk = 1'b0;
    end
    #80 cs_n = 1'b1;
    #80;
  endtask

  task automatic t_reset();
    logic [11:0] g; logic lb;
    chk("R1", "sdo_oe", sdo_oe, 0);
    chk("R1", "sample_win", sample_win, 0);
    chk("R1", "conv_start", conv_start, 0);
    chk("R1", "status_n", status_n, 1);
    frame(8'h50, 12, g, lb);
    chk("R1", "first frame zeros", g, 12'h000);
    chk("R2", "sdo_oe after frame", sdo_oe, 0);
    #700;
    chk("R6", "one start", start_cnt, 1);
    chk("R3", "channel", last_chan, 4'h5);
    exp_prev = res_of(4'h5);
  endtask

  task automatic t_eoc();
    logic [11:0] g; logic lb;
    frame(8'hA0, 12, g, lb);
    chk("R5", "result bits", g, exp_prev);
    chk("R7", "busy low", status_n, 0);
    #700;
    chk("R7", "busy released", status_n, 1);
    chk("R3", "channel", last_chan, 4'hA);
    exp_prev = res_of(4'hA);
  endtask

  task automatic t_irq();
    logic [11:0] g; logic lb; int sc;
    frame(8'h31, 12, g, lb);
    chk("R5", "result bits", g, exp_prev);
    chk("R8", "high while converting", status_n, 1);
    #700;
    chk("R8", "low when ready", status_n, 0);
    exp_prev = res_of(4'h3);
    sc = start_cnt;
    cs_n = 1'b0; #80;
    sclk = 1'b1; #40;
    chk("R8", "cleared by sclk rise", status_n, 1);
    sclk = 1'b0; #40;
    cs_n = 1'b1; #80;
    #700;
    chk("R10", "no start on one-clock frame", start_cnt, sc);
  endtask

  task automatic t_abort();
    logic [11:0] g; logic lb; int sc;
    sc = start_cnt;
    frame(8'h70, 6, g, lb);
    #700;
    chk("R10", "no start on short frame", start_cnt, sc);
    chk("R10", "sample_win idle", sample_win, 0);
    frame(8'hC0, 12, g, lb);
    chk("R10", "result unchanged", g, exp_prev);
    #700;
    chk("R10", "fresh count starts", start_cnt, sc + 1);
    chk("R3", "channel", last_chan, 4'hC);
    exp_prev = res_of(4'hC);
  endtask

  task automatic t_extra();
    logic [11:0] g; logic lb; int sc;
    sc = start_cnt;
    frame(8'h90, 14, g, lb);
    chk("R9", "bits with extra clocks", g, exp_prev);
    chk("R9", "sdo holds bit 0", lb, exp_prev[0]);
    #700;
    chk("R9", "single start", start_cnt, sc + 1);
    chk("R3", "channel", last_chan, 4'h9);
    exp_prev = res_of(4'h9);
  endtask

  task automatic t_overlap();
    logic [11:0] g; logic lb;
    frame(8'h40, 12, g, lb);
    chk("R5", "frame A bits", g, exp_prev);
    frame(8'h60, 12, g, lb);
    chk("R11", "frame B keeps old result", g, exp_prev);
    #700;
    chk("R3", "channel", last_chan, 4'h6);
    frame(8'h00, 12, g, lb);
    chk("R11", "later frame sees newest", g, res_of(4'h6));
  endtask

  initial begin
    repeat (10) @(posedge clk);
    #1 rst = 1'b0;
    #50;
    t_reset();
    t_eoc();
    t_irq();
    t_abort();
    t_extra();
    t_overlap();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL all watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule